// File: doc/BRIEF.md
# Power Island Switching Sequencer

This block drives the on/off controls of up to a few dozen switchable power islands inside a chip. Every island has three kinds of control line: a power-switch line, a module reset line and an output clamp line. A requester asks for one island to be brought up or taken down. The block then walks that island through three steps in a fixed order. It waits a programmable number of settle cycles between steps, and it reports completion with a one-cycle acknowledge. A status vector shows which islands are currently powered.

Each island's wiring is fixed at build time by parameters. Each island names its power-switch bit, its clamp bit and its reset bit, and the value 8'hFF means the island has no line of that kind. Only one island is sequenced at a time. Pending requests wait, and the lowest-numbered island is served first. Requests use a per-island valid/ready pair. The requester raises `req_valid[d]` with `req_up[d]` and holds both until it sees `req_ready[d]` high. The transfer completes on the clock edge where both are high. `req_ready` is the only back-pressure: it stays low until the island's sequence is complete.

Top module: `pwr_island_seq`

## Requirements
- R1: While and after reset, `sw_off` equals `PWR_INIT`. `dom_up[d]` is 1 exactly when island d's power bit in `PWR_INIT` is 0. The clamp and reset bits of powered islands are 1, those of unpowered islands are 0, and unmapped bits are 1. `req_ready` is 0.
- R2: Polarities: `sw_off` bit 1 means unpowered and 0 means powered. `clamp_n` bit 0 clamps the island outputs. `unit_rst_n` bit 0 holds the island in reset.
- R3: Power-down order: first clear the clamp bit, then clear the reset bit, then set the power bit.
- R4: Power-up order: first clear the power bit, then set the reset bit, then set the clamp bit.
- R5: A request is accepted on edge E while `step_gap` = N. The three steps change the outputs on edges E, E+N+1 and E+2N+2, and no output changes in between. At most one control bit changes per cycle.
- R6: When an island has no clamp bit or no reset bit (map value 8'hFF), that step's slot still elapses, but it changes no output. The power step is always applied.
- R7: On the edge that applies the third step, `req_ready[d]` goes high for exactly one cycle and `dom_up[d]` takes the requested state in the same cycle. `dom_up` changes at no other time, and at most one ready bit is high.
- R8: A request for the state an island already has is accepted on edge E. `req_ready[d]` is high in the cycle after E, and no control bit or status bit changes.
- R9: Only one sequence runs at a time. When several islands request at once, the lowest index is served first. A waiting request is held, not lost, and it is started after the running one is acknowledged. `req_ready[d]` is only raised while `req_valid[d]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_gap | input | GAP_W | Settle cycles N inserted between steps |
| req_valid | input | ND | Per-island request valid |
| req_up | input | ND | Per-island requested state, 1 = powered |
| req_ready | output | ND | Per-island one-cycle acknowledge |
| dom_up | output | ND | Per-island powered status |
| sw_off | output | PW | Power-switch bits, 1 = unpowered |
| clamp_n | output | IW | Output clamp bits, 0 = clamped |
| unit_rst_n | output | RW | Module reset bits, 0 = in reset |

## Verification
The bench builds the block with four islands. Their power bits are 3, 2, 1 and 0. Their clamp bits are 0, 1, none and 2. Their reset bits are 16, 18, 20 and none. `PWR_INIT` = 8'h04, so island 1 starts powered down. This configuration makes both skipped-step cases reachable, in both directions. It also puts one island in the down state at reset, so the reset-time derivation of clamp, reset and status bits is exercised. Step gaps of 0 to 3 cycles cover the back-to-back step case as well as the slot-timing case.

// File: rtl/pis_pkg.sv
package pis_pkg;

  localparam logic [7:0] NO_BIT = 8'hFF;

  typedef enum logic { S_IDLE, S_RUN } seq_state_e;

  localparam logic [1:0] STEP_FIRST = 2'd0;
  localparam logic [1:0] STEP_MID   = 2'd1;
  localparam logic [1:0] STEP_LAST  = 2'd2;

  // 8-bit field d of a packed map (island 0 in the low byte)
  function automatic logic [7:0] map_field(logic [255:0] m, int unsigned d);
    return 8'(m >> (8 * d));
  endfunction

  // Bit i of a vector, zero-extended to 256 bits
  function automatic logic bit_at(logic [255:0] v, logic [7:0] i);
    return 1'(v >> i);
  endfunction

endpackage

// File: rtl/pis_pick.sv
module pis_pick #(
  parameter int ND = 4,
  parameter int DW = 2
) (
  input  logic          enable,
  input  logic [ND-1:0] valid,
  input  logic [ND-1:0] up,
  input  logic [ND-1:0] state_up,
  output logic          hit,
  output logic [DW-1:0] idx,
  output logic          dir_up,
  output logic          match
);

  // Scan from the top so that the lowest index is written last and wins.
  always_comb begin
    hit    = 1'b0;
    idx    = '0;
    dir_up = 1'b0;
    match  = 1'b0;
    for (int d = ND - 1; d >= 0; d--) begin
      if (enable && valid[d]) begin
        hit    = 1'b1;
        idx    = DW'(d);
        dir_up = up[d];
        match  = (up[d] == state_up[d]);
      end
    end
  end

endmodule

// File: rtl/pis_gap_timer.sv
module pis_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R5: a loaded gap is counted from its full value
  assert_gap_loaded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/pis_ctrl_bank.sv
module pis_ctrl_bank
  import pis_pkg::*;
#(
  parameter int ND = 4,
  parameter int DW = 2,
  parameter int PW = 8,
  parameter int IW = 8,
  parameter int RW = 32,
  parameter logic [8*ND-1:0] PWR_MAP = '0,
  parameter logic [8*ND-1:0] ISO_MAP = '0,
  parameter logic [8*ND-1:0] RST_MAP = '0,
  parameter logic [PW-1:0]   PWR_INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply,
  input  logic [DW-1:0] dom,
  input  logic          dir_up,
  input  logic [1:0]    step,
  output logic [PW-1:0] sw_off,
  output logic [IW-1:0] clamp_n,
  output logic [RW-1:0] unit_rst_n
);

  function automatic logic starts_off(int unsigned d);
    return bit_at(256'(PWR_INIT), map_field(256'(PWR_MAP), d));
  endfunction

  function automatic logic [IW-1:0] clamp_reset_value();
    logic [IW-1:0] v;
    v = '1;
    for (int unsigned d = 0; d < ND; d++)
      for (int b = 0; b < IW; b++)
        if (map_field(256'(ISO_MAP), d) == 8'(b) && starts_off(d)) v[b] = 1'b0;
    return v;
  endfunction

  function automatic logic [RW-1:0] rst_reset_value();
    logic [RW-1:0] v;
    v = '1;
    for (int unsigned d = 0; d < ND; d++)
      for (int b = 0; b < RW; b++)
        if (map_field(256'(RST_MAP), d) == 8'(b) && starts_off(d)) v[b] = 1'b0;
    return v;
  endfunction

  localparam logic [IW-1:0] CLAMP_INIT = clamp_reset_value();
  localparam logic [RW-1:0] RSTL_INIT  = rst_reset_value();

  logic [7:0]    sel_p, sel_i, sel_r;
  logic [PW-1:0] off_nx;
  logic [IW-1:0] cl_nx;
  logic [RW-1:0] rs_nx;

  // Bit numbers of the island being stepped
  always_comb begin
    sel_p = NO_BIT;
    sel_i = NO_BIT;
    sel_r = NO_BIT;
    for (int unsigned d = 0; d < ND; d++) begin
      if (dom == DW'(d)) begin
        sel_p = map_field(256'(PWR_MAP), d);
        sel_i = map_field(256'(ISO_MAP), d);
        sel_r = map_field(256'(RST_MAP), d);
      end
    end
  end

  // One control bit moves per applied step; an unmapped bit matches nothing.
  always_comb begin
    off_nx = sw_off;
    cl_nx  = clamp_n;
    rs_nx  = unit_rst_n;
    if (apply) begin
      if (!dir_up) begin
        if (step == STEP_FIRST) begin
          for (int b = 0; b < IW; b++) if (sel_i == 8'(b)) cl_nx[b] = 1'b0;
        end else if (step == STEP_MID) begin
          for (int b = 0; b < RW; b++) if (sel_r == 8'(b)) rs_nx[b] = 1'b0;
        end else begin
          for (int b = 0; b < PW; b++) if (sel_p == 8'(b)) off_nx[b] = 1'b1;
        end
      end else begin
        if (step == STEP_FIRST) begin
          for (int b = 0; b < PW; b++) if (sel_p == 8'(b)) off_nx[b] = 1'b0;
        end else if (step == STEP_MID) begin
          for (int b = 0; b < RW; b++) if (sel_r == 8'(b)) rs_nx[b] = 1'b1;
        end else begin
          for (int b = 0; b < IW; b++) if (sel_i == 8'(b)) cl_nx[b] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_off     <= PWR_INIT;
      clamp_n    <= CLAMP_INIT;
      unit_rst_n <= RSTL_INIT;
    end else begin
      sw_off     <= off_nx;
      clamp_n    <= cl_nx;
      unit_rst_n <= rs_nx;
    end
  end

  // R5: never more than one control line moves on an edge
  assert_one_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sw_off, clamp_n, unit_rst_n} ^ $past({sw_off, clamp_n, unit_rst_n})) <= 1);

  // Per-island ordering checks
  for (genvar d = 0; d < ND; d++) begin : g_order
    localparam logic [7:0] P = map_field(256'(PWR_MAP), d);
    localparam logic [7:0] I = map_field(256'(ISO_MAP), d);
    localparam logic [7:0] R = map_field(256'(RST_MAP), d);

    if (I != NO_BIT) begin : g_iso
      assert_clamp_before_cut_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_off[P]) |-> !clamp_n[I]);
      assert_clamp_release_powered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_n[I]) |-> !sw_off[P]);
    end
    if (R != NO_BIT) begin : g_rst
      assert_reset_before_cut_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_off[P]) |-> !unit_rst_n[R]);
      assert_release_after_power_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unit_rst_n[R]) |-> !sw_off[P]);
    end
    if (I != NO_BIT && R != NO_BIT) begin : g_both
      assert_reset_after_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unit_rst_n[R]) |-> !clamp_n[I]);
      assert_clamp_after_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_n[I]) |-> unit_rst_n[R]);
    end
  end

endmodule

// File: rtl/pwr_island_seq.sv
module pwr_island_seq
  import pis_pkg::*;
#(
  parameter int ND    = 4,
  parameter int PW    = 8,
  parameter int IW    = 8,
  parameter int RW    = 32,
  parameter int GAP_W = 4,
  parameter logic [8*ND-1:0] PWR_MAP  = 32'h00_01_02_03,
  parameter logic [8*ND-1:0] ISO_MAP  = 32'h02_FF_01_00,
  parameter logic [8*ND-1:0] RST_MAP  = 32'hFF_14_12_10,
  parameter logic [PW-1:0]   PWR_INIT = 8'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] step_gap,
  input  logic [ND-1:0]    req_valid,
  input  logic [ND-1:0]    req_up,
  output logic [ND-1:0]    req_ready,
  output logic [ND-1:0]    dom_up,
  output logic [PW-1:0]    sw_off,
  output logic [IW-1:0]    clamp_n,
  output logic [RW-1:0]    unit_rst_n
);

  localparam int DW = (ND > 1) ? $clog2(ND) : 1;

  function automatic logic [ND-1:0] status_reset_value();
    logic [ND-1:0] v;
    v = '0;
    for (int unsigned d = 0; d < ND; d++)
      v[d] = !bit_at(256'(PWR_INIT), map_field(256'(PWR_MAP), d));
    return v;
  endfunction

  localparam logic [ND-1:0] UP_INIT = status_reset_value();

  seq_state_e    state;
  logic [DW-1:0] cur_dom;
  logic          cur_up;
  logic [1:0]    step_q;
  logic [ND-1:0] ack_q;

  logic          pick_en, pick_hit, pick_dir, pick_match;
  logic [DW-1:0] pick_idx;
  logic          gap_done, gap_load;
  logic          apply;
  logic [DW-1:0] a_dom;
  logic          a_up;
  logic [1:0]    a_step;
  logic [ND-1:0] cur_oh;

  // No new grant while an acknowledge is out, so a held valid is not served twice.
  assign pick_en = (state == S_IDLE) && (ack_q == '0);

  pis_pick #(.ND(ND), .DW(DW)) u_pick (
    .enable   (pick_en),
    .valid    (req_valid),
    .up       (req_up),
    .state_up (dom_up),
    .hit      (pick_hit),
    .idx      (pick_idx),
    .dir_up   (pick_dir),
    .match    (pick_match)
  );

  pis_gap_timer #(.W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (step_gap),
    .expired  (gap_done)
  );

  always_comb begin
    apply    = 1'b0;
    gap_load = 1'b0;
    a_dom    = cur_dom;
    a_up     = cur_up;
    a_step   = step_q;
    if (state == S_IDLE) begin
      if (pick_hit && !pick_match) begin
        apply    = 1'b1;
        gap_load = 1'b1;
        a_dom    = pick_idx;
        a_up     = pick_dir;
        a_step   = STEP_FIRST;
      end
    end else if (gap_done) begin
      apply    = 1'b1;
      gap_load = (step_q != STEP_LAST);
    end
  end

  pis_ctrl_bank #(
    .ND(ND), .DW(DW), .PW(PW), .IW(IW), .RW(RW),
    .PWR_MAP(PWR_MAP), .ISO_MAP(ISO_MAP), .RST_MAP(RST_MAP), .PWR_INIT(PWR_INIT)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .apply      (apply),
    .dom        (a_dom),
    .dir_up     (a_up),
    .step       (a_step),
    .sw_off     (sw_off),
    .clamp_n    (clamp_n),
    .unit_rst_n (unit_rst_n)
  );

  assign cur_oh = ND'(1) << cur_dom;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur_dom <= '0;
      cur_up  <= 1'b0;
      step_q  <= STEP_FIRST;
      ack_q   <= '0;
      dom_up  <= UP_INIT;
    end else begin
      ack_q <= '0;
      unique case (state)
        S_IDLE: begin
          if (pick_hit) begin
            if (pick_match) begin
              ack_q <= ND'(1) << pick_idx;
            end else begin
              cur_dom <= pick_idx;
              cur_up  <= pick_dir;
              step_q  <= STEP_MID;
              state   <= S_RUN;
            end
          end
        end
        S_RUN: begin
          if (gap_done) begin
            if (step_q == STEP_LAST) begin
              ack_q  <= cur_oh;
              dom_up <= cur_up ? (dom_up | cur_oh) : (dom_up & ~cur_oh);
              state  <= S_IDLE;
            end else begin
              step_q <= step_q + 2'd1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = ack_q;

  // R7: a single island is acknowledged at a time
  assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  // R7: status moves only together with an acknowledge
  assert_status_on_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dom_up) |-> (|req_ready));

  // R9: an acknowledge answers a live request
  assert_ack_has_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |-> (|(req_ready & req_valid)));

  // R5: controls hold still while the settle gap runs
  assert_gap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && !gap_done) |=>
      ($stable(sw_off) && $stable(clamp_n) && $stable(unit_rst_n)));

  // R8: a request for the present state is acknowledged with nothing moved
  assert_match_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_en && pick_hit && pick_match) |=>
      ($stable(sw_off) && $stable(clamp_n) && $stable(unit_rst_n) &&
       $stable(dom_up) && (|req_ready)));

endmodule

// File: tb/pwr_island_seq_test.sv
module pwr_island_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int ND = 4;
  localparam int PW = 8;
  localparam int IW = 8;
  localparam int RW = 32;
  localparam int GAP_W = 4;

  // Island wiring: power bit, clamp bit, reset bit (-1 = none)
  localparam int BP [ND] = '{3, 2, 1, 0};
  localparam int BI [ND] = '{0, 1, -1, 2};
  localparam int BR [ND] = '{16, 18, 20, -1};

  typedef struct packed {
    logic [1:0] dom;
    logic       up;
    logic [3:0] gap;
    logic [3:0] up_after;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 4'd2, 4'b1100},
    '{2'd1, 1'b1, 4'd0, 4'b1110},
    '{2'd2, 1'b0, 4'd1, 4'b1010},
    '{2'd3, 1'b0, 4'd3, 4'b0010},
    '{2'd0, 1'b0, 4'd1, 4'b0010},
    '{2'd0, 1'b1, 4'd2, 4'b0011},
    '{2'd3, 1'b1, 4'd0, 4'b1011},
    '{2'd2, 1'b1, 4'd2, 4'b1111},
    '{2'd1, 1'b1, 4'd1, 4'b1111},
    '{2'd1, 1'b0, 4'd0, 4'b1101}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [GAP_W-1:0] step_gap = '0;
  logic [ND-1:0]    req_valid = '0;
  logic [ND-1:0]    req_up = '0;
  logic [ND-1:0]    req_ready;
  logic [ND-1:0]    dom_up;
  logic [PW-1:0]    sw_off;
  logic [IW-1:0]    clamp_n;
  logic [RW-1:0]    unit_rst_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [PW-1:0] m_off;
  logic [IW-1:0] m_cl;
  logic [RW-1:0] m_rs;
  logic [ND-1:0] m_up;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwr_island_seq #(
    .ND(ND), .PW(PW), .IW(IW), .RW(RW), .GAP_W(GAP_W),
    .PWR_MAP(32'h00_01_02_03), .ISO_MAP(32'h02_FF_01_00),
    .RST_MAP(32'hFF_14_12_10), .PWR_INIT(8'h04)
  ) uut (
    .clk(clk), .rst_n(rst_n), .step_gap(step_gap),
    .req_valid(req_valid), .req_up(req_up), .req_ready(req_ready),
    .dom_up(dom_up), .sw_off(sw_off), .clamp_n(clamp_n), .unit_rst_n(unit_rst_n)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_off = 8'h04;
    m_cl  = '1;
    m_rs  = '1;
    for (int d = 0; d < ND; d++) begin
      m_up[d] = !m_off[BP[d]];
      if (!m_up[d]) begin
        if (BI[d] >= 0) m_cl[BI[d]] = 1'b0;
        if (BR[d] >= 0) m_rs[BR[d]] = 1'b0;
      end
    end
  endtask

  task automatic model_step(input int d, input bit up, input int k);
    if (!up) begin
      if (k == 0 && BI[d] >= 0) m_cl[BI[d]] = 1'b0;
      if (k == 1 && BR[d] >= 0) m_rs[BR[d]] = 1'b0;
      if (k == 2) m_off[BP[d]] = 1'b1;
    end else begin
      if (k == 0) m_off[BP[d]] = 1'b0;
      if (k == 1 && BR[d] >= 0) m_rs[BR[d]] = 1'b1;
      if (k == 2 && BI[d] >= 0) m_cl[BI[d]] = 1'b1;
    end
  endtask

  task automatic cmp_outputs(input string tag);
    check(sw_off == m_off, {tag, " sw_off"}, 32'(sw_off), 32'(m_off));
    check(clamp_n == m_cl, {tag, " clamp_n"}, 32'(clamp_n), 32'(m_cl));
    check(unit_rst_n == m_rs, {tag, " unit_rst_n"}, unit_rst_n, m_rs);
  endtask

  function automatic string step_tag(input int d, input bit up, input int k);
    if (!up) begin
      if (k == 0) return (BI[d] < 0) ? "R6 skipped clamp slot" : "R3 clamp first";
      if (k == 1) return (BR[d] < 0) ? "R6 skipped reset slot" : "R3 reset second";
      return "R3/R2 power cut last";
    end
    if (k == 0) return "R4/R2 power restored first";
    if (k == 1) return (BR[d] < 0) ? "R6 skipped reset slot" : "R4 reset released second";
    return (BI[d] < 0) ? "R6 skipped clamp slot" : "R4 clamp released last";
  endfunction

  task automatic run_req(input int d, input bit up, input int gap, input logic [3:0] exp_up);
    step_gap     = GAP_W'(gap);
    req_up[d]    = up;
    req_valid[d] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (m_up[d] == up) begin
      check(req_ready == ND'(1 << d), "R8 matching request acked", 32'(req_ready), 32'(1 << d));
      cmp_outputs("R8 matching request quiet");
      check(dom_up == exp_up, "R8 status kept", 32'(dom_up), 32'(exp_up));
    end else begin
      for (int k = 0; k < 3; k++) begin
        if (k > 0) begin
          if (gap > 0) begin
            repeat (gap) @(negedge clk);
            cmp_outputs("R5 held during gap");
            check(req_ready == '0, "R7 no early ready", 32'(req_ready), 32'h0);
          end
          @(negedge clk);
        end
        model_step(d, up, k);
        cmp_outputs(step_tag(d, up, k));
        if (k < 2)
          check(req_ready == '0, "R7 ready only at end", 32'(req_ready), 32'h0);
      end
      m_up[d] = up;
      check(req_ready == ND'(1 << d), "R7 ready with last step", 32'(req_ready), 32'(1 << d));
      check(dom_up == exp_up, "R7 status with last step", 32'(dom_up), 32'(exp_up));
    end
    m_up[d] = up;
    @(negedge clk);
    req_valid[d] = 1'b0;
    check(req_ready == '0, "R7 single ready pulse", 32'(req_ready), 32'h0);
  endtask

  task automatic wait_ready(input int d, output bit got);
    got = 1'b0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (req_ready[d]) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic check_reset_state(input string tag);
    check(sw_off == 8'h04, {tag, " R1 sw_off"}, 32'(sw_off), 32'h04);
    check(clamp_n == 8'hFD, {tag, " R1 clamp_n"}, 32'(clamp_n), 32'hFD);
    check(unit_rst_n == 32'hFFFB_FFFF, {tag, " R1 unit_rst_n"}, unit_rst_n, 32'hFFFB_FFFF);
    check(dom_up == 4'b1101, {tag, " R1 dom_up"}, 32'(dom_up), 32'hD);
    check(req_ready == '0, {tag, " R1 req_ready"}, 32'(req_ready), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit got;
    model_reset();
    repeat (3) @(negedge clk);
    check_reset_state("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("after reset");

    // Table of requests with expected status afterwards
    for (int v = 0; v < NV; v++) begin
      run_req(int'(VECS[v].dom), VECS[v].up, int'(VECS[v].gap), VECS[v].up_after);
      check(m_up == VECS[v].up_after, "R7 model status", 32'(m_up), 32'(VECS[v].up_after));
    end

    // R9: two islands at once, lowest index first, the other held
    step_gap     = 4'd1;
    req_up[1]    = 1'b1;
    req_up[2]    = 1'b0;
    req_valid[1] = 1'b1;
    req_valid[2] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    model_step(1, 1'b1, 0);
    cmp_outputs("R9 lowest index first");
    wait_ready(1, got);
    check(got, "R9 first island acked", 32'(got), 32'h1);
    check(req_ready[2] == 1'b0, "R9 second island waits", 32'(req_ready), 32'h2);
    model_step(1, 1'b1, 1);
    model_step(1, 1'b1, 2);
    cmp_outputs("R9 second island untouched");
    @(negedge clk);
    req_valid[1] = 1'b0;
    wait_ready(2, got);
    check(got, "R9 held request served", 32'(got), 32'h1);
    model_step(2, 1'b0, 0);
    model_step(2, 1'b0, 1);
    model_step(2, 1'b0, 2);
    cmp_outputs("R9 held request sequence");
    check(dom_up == 4'b1011, "R9 status after both", 32'(dom_up), 32'hB);
    @(negedge clk);
    req_valid[2] = 1'b0;

    // R1: reset from a changed state restores the reset values
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("second reset");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule